// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block sits in front of a small shared register file and settles, in a single cycle, what happens when several processors write to it at once. Each of P processors presents a valid bit, a word address and a data value. Writers that name the same word form a group. A 2-bit policy input selects how each group is resolved:

- exclusive: any sharing of a word is an error;
- common: sharing is legal only when every value in the group is the same;
- arbitrary: one writer is chosen by a rotating pointer;
- priority: the lowest processor index wins.

The block reports the outcome in two ways. A per-processor grant vector shows which writes took effect, and a single violation flag shows whether any group broke the selected policy. Both are combinational on the request inputs. Granted writes commit to the register file on the next rising clock edge. A combinational read port lets the surrounding logic observe any word.

Top module: `cw_resolver`

## Requirements
- R1: While rst_n is low, every word of the register file is cleared to zero and the arbitrary-mode pointer is set to processor 0.
- R2: A grant bit is only ever high for a processor whose valid bit is high. A valid writer that is the only one addressing its word is granted in every mode.
- R3: In exclusive mode (mode = 00), two or more valid writers to one word raise viol, none of them is granted, and that word keeps its old value. Writers to other words are not affected.
- R4: In common mode (mode = 01), writers to one word that all carry the same value are all granted, and that value is committed.
- R5: In common mode, a word addressed with unequal values raises viol. None of its writers is granted, and the word keeps its old value.
- R6: In priority mode (mode = 11), the valid writer with the smallest index in each group is granted, the others are dropped, and viol stays low.
- R7: In arbitrary mode (mode = 10), exactly one writer in each group is granted, its value is committed, and viol stays low.
- R8: In arbitrary mode, the winner of a group is the first of its writers found by counting upward (with wrap) from the pointer. The pointer advances by one after each arbitrary-mode cycle in which any grant is given.
- R9: Granted data is visible on rd_data after the next rising edge. In a cycle with no grant, the register file does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Write policy: 00 exclusive, 01 common, 10 arbitrary, 11 priority |
| req_valid | input | P | Per-processor write request |
| req_addr | input | P*AW | Word address, processor i in bits [i*AW +: AW] |
| req_data | input | P*DW | Write data, processor i in bits [i*DW +: DW] |
| grant | output | P | Per-processor write took effect this cycle |
| viol | output | 1 | A group broke the selected policy this cycle |
| rd_addr | input | AW | Read port address |
| rd_data | output | DW | Word at rd_addr |

## Verification
The bench builds the block with P=4, AW=3, DW=8. With four processors, two separate colliding groups can be present in one cycle, so the bench can show that one group's violation leaves the other group's grants intact. Four writers are also few enough that a full rotation of the arbitrary pointer completes in four cycles. Eight words leave room to check commit and no-commit results at distinct addresses without any interference between them.

// File: rtl/cw_resolver.sv
module cw_resolver #(
  parameter int P  = 4,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [P-1:0]    req_valid,
  input  logic [P*AW-1:0] req_addr,
  input  logic [P*DW-1:0] req_data,
  output logic [P-1:0]    grant,
  output logic            viol,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data
);
  localparam int WORDS = 1 << AW;
  localparam int PW    = (P > 1) ? $clog2(P) : 1;

  logic [DW-1:0] mem [WORDS];
  logic [PW-1:0] ptr;
  logic [P-1:0]  shared, mismatch, lower, ahead;

  always_comb begin
    for (int i = 0; i < P; i++) begin
      shared[i]   = 1'b0;
      mismatch[i] = 1'b0;
      lower[i]    = 1'b0;
      ahead[i]    = 1'b0;
      for (int j = 0; j < P; j++) begin
        if (j != i && req_valid[i] && req_valid[j] &&
            req_addr[j*AW +: AW] == req_addr[i*AW +: AW]) begin
          shared[i] = 1'b1;
          if (req_data[j*DW +: DW] != req_data[i*DW +: DW]) mismatch[i] = 1'b1;
          if (j < i) lower[i] = 1'b1;
          if (((j + P - int'(ptr)) % P) < ((i + P - int'(ptr)) % P)) ahead[i] = 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (mode)
      2'b00:   grant = req_valid & ~shared;
      2'b01:   grant = req_valid & ~mismatch;
      2'b10:   grant = req_valid & ~ahead;
      default: grant = req_valid & ~lower;
    endcase
  end

  assign viol = (mode == 2'b00) ? |(req_valid & shared) :
                (mode == 2'b01) ? |(req_valid & mismatch) : 1'b0;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      ptr <= '0;
    end else begin
      for (int i = 0; i < P; i++)
        if (grant[i]) mem[req_addr[i*AW +: AW]] <= req_data[i*DW +: DW];
      if (mode == 2'b10 && |grant)
        ptr <= (int'(ptr) == P - 1) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/cw_resolver_chk.sv
module cw_resolver_chk #(
  parameter int P  = 4,
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [P-1:0]  req_valid,
  input logic [P-1:0]  grant,
  input logic          viol,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  a_r2_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req_valid) == '0);

  a_r3_excl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && viol) |-> grant != req_valid);

  a_r4_common_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !viol) |-> grant == req_valid);

  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && req_valid[0]) |-> grant[0]);

  a_r7_no_viol_arb_prio: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> !viol);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> ($stable(rd_addr) -> $stable(rd_data)));
endmodule

bind cw_resolver cw_resolver_chk #(.P(P), .AW(AW), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
  .grant(grant), .viol(viol), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/cw_resolver_test.sv
module cw_resolver_test;
  localparam int P = 4, AW = 3, DW = 8;
  localparam int NV = 10;
  // {mode, valid, addr p3..p0, data p3..p0, expected grant, expected viol}
  localparam logic [54:0] VEC [NV] = '{
    {2'b00, 4'b0011, {3'd0,3'd0,3'd2,3'd1}, 32'h0,         4'b0011, 1'b0},
    {2'b00, 4'b0111, {3'd0,3'd5,3'd5,3'd1}, 32'h0,         4'b0001, 1'b1},
    {2'b01, 4'b1111, {3'd3,3'd3,3'd3,3'd3}, 32'h5A5A5A5A,  4'b1111, 1'b0},
    {2'b01, 4'b0111, {3'd0,3'd4,3'd4,3'd4}, 32'h00221111,  4'b0000, 1'b1},
    {2'b01, 4'b1111, {3'd6,3'd6,3'd2,3'd2}, 32'h08070101,  4'b0011, 1'b1},
    {2'b01, 4'b1111, {3'd3,3'd2,3'd1,3'd0}, 32'h04030201,  4'b1111, 1'b0},
    {2'b11, 4'b1110, {3'd7,3'd7,3'd7,3'd7}, 32'h33221100,  4'b0010, 1'b0},
    {2'b11, 4'b1111, {3'd1,3'd0,3'd1,3'd0}, 32'h0,         4'b0011, 1'b0},
    {2'b11, 4'b1000, {3'd5,3'd0,3'd0,3'd0}, 32'h0,         4'b1000, 1'b0},
    {2'b00, 4'b0000, {3'd0,3'd0,3'd0,3'd0}, 32'h0,         4'b0000, 1'b0}
  };

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic [P-1:0]    req_valid = '0;
  logic [P*AW-1:0] req_addr = '0;
  logic [P*DW-1:0] req_data = '0;
  logic [P-1:0]    grant;
  logic            viol;
  logic [AW-1:0]   rd_addr = '0;
  logic [DW-1:0]   rd_data;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  cw_resolver #(.P(P), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_data(req_data), .grant(grant), .viol(viol),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] m, input logic [3:0] v,
                       input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    mode = m; req_valid = v; req_addr = a; req_data = d;
    #1;
  endtask

  task automatic commit_and_read(input logic [AW-1:0] ad);
    @(posedge clk);
    req_valid = '0;
    rd_addr = ad;
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      rd_addr = w[AW-1:0]; #0.1;
      chk(rd_data == 8'h00, "R1 reset clears word", rd_data, 0);
    end
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][54:53], VEC[k][52:49], VEC[k][48:37], VEC[k][36:5]);
      chk(grant == VEC[k][4:1], $sformatf("R2/R3/R4/R5/R6 vector %0d grant", k), grant, VEC[k][4:1]);
      chk(viol == VEC[k][0], $sformatf("R3/R5 vector %0d viol", k), viol, VEC[k][0]);
    end

    // fresh reset: arbitrary pointer starts at 0
    @(negedge clk); rst_n = 1'b0; req_valid = '0;
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      drive(2'b10, 4'b1111, {3'd2,3'd2,3'd2,3'd2}, 32'hA3A2A1A0);
      chk($countones(grant) == 1, "R7 one arbitrary winner", grant, 1);
      chk(grant == (4'b0001 << k), "R8 rotation order", grant, 4'b0001 << k);
      chk(viol == 1'b0, "R7 no viol", viol, 0);
      commit_and_read(3'd2);
      chk(rd_data == 8'hA0 + k, "R7 winner data committed", rd_data, 8'hA0 + k);
    end
    drive(2'b10, 4'b1010, {3'd6,3'd0,3'd6,3'd0}, 32'hB3B2B1B0);
    chk(grant == 4'b0010, "R8 first writer from pointer", grant, 4'b0010);
    commit_and_read(3'd6);
    chk(rd_data == 8'hB1, "R8 data", rd_data, 8'hB1);

    drive(2'b00, 4'b0011, {3'd0,3'd0,3'd5,3'd5}, 32'h00000909);
    commit_and_read(3'd5);
    chk(rd_data == 8'h00, "R3 word unchanged on violation", rd_data, 0);

    drive(2'b01, 4'b0111, {3'd0,3'd4,3'd4,3'd4}, 32'h00221111);
    commit_and_read(3'd4);
    chk(rd_data == 8'h00, "R5 word unchanged on mismatch", rd_data, 0);

    drive(2'b01, 4'b1111, {3'd3,3'd3,3'd3,3'd3}, 32'h5A5A5A5A);
    commit_and_read(3'd3);
    chk(rd_data == 8'h5A, "R4 merged value committed", rd_data, 8'h5A);

    drive(2'b11, 4'b1110, {3'd7,3'd7,3'd7,3'd7}, 32'h33221100);
    commit_and_read(3'd7);
    chk(rd_data == 8'h11, "R6 lowest index value committed", rd_data, 8'h11);

    drive(2'b00, 4'b0000, {3'd7,3'd7,3'd7,3'd7}, 32'hFFFFFFFF);
    commit_and_read(3'd7);
    chk(rd_data == 8'h11, "R9 idle cycle leaves memory", rd_data, 8'h11);

    @(negedge clk); rst_n = 1'b0; #1;
    chk(rd_data == 8'h00, "R1 reset clears written word", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule